// File: doc/BRIEF.md
# Multi-Mode Effective Address Generator

This block turns the operand fields of an already decoded memory instruction into an effective address. It takes a 3-bit mode selector, a base register value, an index register value, a 2-bit scale code, a raw displacement with a 2-bit width code, and the current program counter. It supports eight ways of forming the address. Two of those modes also return an updated base value and a write-back enable, so the register file can apply the side effect of an auto-update access.

Each request arrives with `in_valid`. The address, the write-back value, the write-back enable and `out_valid` are all registered. They appear one clock after the request. All address arithmetic wraps modulo 2^AW and has no overflow indication. When no request is present, the address and write-back value registers keep their last contents. The write-back enable and `out_valid` both drop to 0.

The scale factor is applied as a left shift, so no multiplier is used. The displacement is sign-extended before any addition.

Top module: `eff_addr_unit`

## Requirements
- R1: While `rst` is high, and on the first clock after it, `out_valid`, `wb_en`, `addr` and `wb_val` are all 0.
- R2: `out_valid` is 1 on the clock after a cycle with `in_valid`=1, and 0 on the clock after a cycle with `in_valid`=0.
- R3: The displacement is sign-extended to AW bits before use. Width code 0 takes bits [7:0], code 1 takes bits [15:0], and codes 2 and 3 take all 32 bits.
- R4: Mode 0 (absolute) gives an address equal to the extended displacement alone.
- R5: Mode 1 (register indirect) gives an address equal to the base value.
- R6: Mode 2 (displacement) gives base plus the extended displacement.
- R7: Mode 3 (base plus index) gives base plus index, and the displacement is ignored.
- R8: Mode 4 (scaled) gives base plus (index shifted left by the scale code) plus the extended displacement. Scale codes 0, 1, 2 and 3 mean ×1, ×2, ×4 and ×8.
- R9: Mode 5 (PC-relative) gives the program counter plus the extended displacement.
- R10: Mode 6 (auto-increment) gives an address equal to the base, a write-back value of base+1, and `wb_en`=1.
- R11: Mode 7 (auto-indexing) gives base plus the extended displacement as the address, the same value as `wb_val`, and `wb_en`=1.
- R12: `wb_en` is 1 only on the clock after an accepted request in mode 6 or mode 7. It is 0 on every other clock.
- R13: All sums wrap modulo 2^AW. For example, with AW=32, base 0xFFFFFFFF plus displacement 2 gives 0x00000001.
- R14: After a cycle with `in_valid`=0, `addr` and `wb_val` hold their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| mode | input | 3 | Address mode selector (0..7) |
| disp_sz | input | 2 | Displacement width code |
| scale | input | 2 | Index shift amount |
| base | input | AW | Base register value |
| index | input | AW | Index register value |
| disp | input | DW | Raw displacement field |
| pc | input | AW | Current program counter |
| out_valid | output | 1 | Registered result valid |
| addr | output | AW | Effective address |
| wb_val | output | AW | Updated base value for write-back |
| wb_en | output | 1 | Base write-back enable |

## Verification
The assertions check the following on every cycle:
- the one-cycle valid latency;
- that `wb_en` is confined to the two auto-update modes;
- the base+1 write-back value;
- the match between address and write-back value in auto-indexing;
- the pass-through of the base in register-indirect mode;
- holding of the output registers while idle.

The arithmetic of the modes that add a displacement or a scaled index needs the bench's scenarios. This covers the 8-, 16- and 32-bit sign extension at each sign boundary, all four scale codes, the ignored displacement in base-plus-index mode, and wrap-around past 2^32. The bench's reference model covers these, using directed vectors followed by a long random stream.

// File: rtl/eff_addr_pkg.sv
package eff_addr_pkg;
  typedef enum logic [2:0] {
    AM_ABS   = 3'd0,
    AM_IND   = 3'd1,
    AM_DISP  = 3'd2,
    AM_BIDX  = 3'd3,
    AM_SCALE = 3'd4,
    AM_PCREL = 3'd5,
    AM_AINC  = 3'd6,
    AM_AIDX  = 3'd7
  } am_mode_e;

  localparam int NUM_DSZ = 3;
endpackage

// File: rtl/eff_addr_sext.sv
module eff_addr_sext #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic [DW-1:0] raw,
  input  logic [1:0]    sz,
  output logic [AW-1:0] ext
);
  import eff_addr_pkg::*;

  logic [AW-1:0] cand [NUM_DSZ];

  for (genvar g = 0; g < NUM_DSZ; g++) begin : g_width
    localparam int W = (g == 0) ? 8 : (g == 1) ? 16 : DW;
    logic signed [W-1:0] slice;
    assign slice   = raw[W-1:0];
    assign cand[g] = AW'(slice);
  end

  always_comb begin
    case (sz)
      2'd0:    ext = cand[0];
      2'd1:    ext = cand[1];
      default: ext = cand[2];
    endcase
  end
endmodule

// File: rtl/eff_addr_scaler.sv
module eff_addr_scaler #(
  parameter int AW = 32,
  parameter int SW = 2
) (
  input  logic [AW-1:0] idx,
  input  logic [SW-1:0] shamt,
  output logic [AW-1:0] scaled
);
  localparam int NSTEP = 1 << SW;

  logic [AW-1:0] opts [NSTEP];

  for (genvar s = 0; s < NSTEP; s++) begin : g_shift
    assign opts[s] = idx << s;
  end

  assign scaled = opts[shamt];
endmodule

// File: rtl/eff_addr_unit.sv
module eff_addr_unit #(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int SW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [2:0]    mode,
  input  logic [1:0]    disp_sz,
  input  logic [SW-1:0] scale,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] index,
  input  logic [DW-1:0] disp,
  input  logic [AW-1:0] pc,
  output logic          out_valid,
  output logic [AW-1:0] addr,
  output logic [AW-1:0] wb_val,
  output logic          wb_en
);
  import eff_addr_pkg::*;

  logic [AW-1:0] disp_x;
  logic [AW-1:0] idx_s;
  logic [AW-1:0] op_a, op_b, op_c;
  logic [AW-1:0] addr_n, wb_n;
  logic          upd_n;
  am_mode_e      m;

  assign m = am_mode_e'(mode);

  eff_addr_sext #(.AW(AW), .DW(DW)) u_sext (
    .raw (disp),
    .sz  (disp_sz),
    .ext (disp_x)
  );

  eff_addr_scaler #(.AW(AW), .SW(SW)) u_scale (
    .idx    (index),
    .shamt  (scale),
    .scaled (idx_s)
  );

  // one three-input adder shared by every mode; unused legs are zero
  always_comb begin
    op_a  = '0;
    op_b  = '0;
    op_c  = '0;
    upd_n = 1'b0;
    case (m)
      AM_ABS:   op_c = disp_x;
      AM_IND:   op_a = base;
      AM_DISP:  begin op_a = base; op_c = disp_x; end
      AM_BIDX:  begin op_a = base; op_b = index; end
      AM_SCALE: begin op_a = base; op_b = idx_s; op_c = disp_x; end
      AM_PCREL: begin op_a = pc;   op_c = disp_x; end
      AM_AINC:  begin op_a = base; upd_n = 1'b1; end
      AM_AIDX:  begin op_a = base; op_c = disp_x; upd_n = 1'b1; end
      default:  op_a = base;
    endcase
  end

  assign addr_n = op_a + op_b + op_c;
  assign wb_n   = (m == AM_AINC) ? base + AW'(1) : addr_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      wb_en     <= 1'b0;
      addr      <= '0;
      wb_val    <= '0;
    end else begin
      out_valid <= in_valid;
      wb_en     <= in_valid & upd_n;
      if (in_valid) begin
        addr   <= addr_n;
        wb_val <= wb_n;
      end
    end
  end
endmodule

// File: rtl/eff_addr_unit_chk.sv
module eff_addr_unit_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic [2:0]    mode,
  input logic [AW-1:0] base,
  input logic          out_valid,
  input logic [AW-1:0] addr,
  input logic [AW-1:0] wb_val,
  input logic          wb_en
);
  p_valid_on_r2: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  p_valid_off_r2: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  p_wb_only_auto_r12: assert property (@(posedge clk) disable iff (rst)
    !(in_valid && (mode == 3'd6 || mode == 3'd7)) |=> !wb_en);
  p_ainc_wb_r10: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mode == 3'd6) |=> (wb_en && wb_val == $past(base) + AW'(1) && addr == $past(base)));
  p_aidx_same_r11: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mode == 3'd7) |=> (wb_en && wb_val == addr));
  p_ind_base_r5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mode == 3'd1) |=> addr == $past(base));
  p_idle_hold_r14: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(addr) && $stable(wb_val)));
endmodule

bind eff_addr_unit eff_addr_unit_chk #(.AW(AW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .mode      (mode),
  .base      (base),
  .out_valid (out_valid),
  .addr      (addr),
  .wb_val    (wb_val),
  .wb_en     (wb_en)
);

// File: tb/eff_addr_unit_test.sv
module eff_addr_unit_test;
  localparam int AW = 32;
  localparam longint MASK = 64'hFFFF_FFFF;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic [2:0]    mode = '0;
  logic [1:0]    disp_sz = '0;
  logic [1:0]    scale = '0;
  logic [31:0]   base = '0, index = '0, disp = '0, pc = '0;
  logic          out_valid, wb_en;
  logic [31:0]   addr, wb_val;

  int n_run = 0;
  int n_fail = 0;

  // reference state
  bit      e_vld = 0, e_wen = 0;
  longint  e_addr = 0, e_wb = 0;

  always #4 clk = ~clk;

  eff_addr_unit uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .mode(mode), .disp_sz(disp_sz),
    .scale(scale), .base(base), .index(index), .disp(disp), .pc(pc),
    .out_valid(out_valid), .addr(addr), .wb_val(wb_val), .wb_en(wb_en)
  );

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog: run did not complete (actual hung, expected done)");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  function automatic longint sx(longint d, int sz);
    longint v;
    if (sz == 0) begin v = d % 256;   if (v >= 128)   v -= 256;   end
    else if (sz == 1) begin v = d % 65536; if (v >= 32768) v -= 65536; end
    else begin v = d; if (v >= 64'h8000_0000) v -= 64'h1_0000_0000; end
    return v;
  endfunction

  task automatic check(string tag);
    n_run++;
    if (out_valid !== e_vld || wb_en !== e_wen ||
        addr !== e_addr[31:0] || wb_val !== e_wb[31:0]) begin
      n_fail++;
      $display("FAIL %s: actual v=%0b a=%h w=%h we=%0b expected v=%0b a=%h w=%h we=%0b",
               tag, out_valid, addr, wb_val, wb_en, e_vld,
               e_addr[31:0], e_wb[31:0], e_wen);
    end
  endtask

  task automatic issue(bit v, int md, int dz, int sc, longint b, longint ix,
                       longint d, longint p, string tag);
    longint dx, a, w;
    @(negedge clk);
    in_valid = v; mode = md[2:0]; disp_sz = dz[1:0]; scale = sc[1:0];
    base = b[31:0]; index = ix[31:0]; disp = d[31:0]; pc = p[31:0];
    dx = sx(d & MASK, dz);
    a = b; w = 0;
    case (md)
      0: a = dx;
      1: a = b;
      2: a = b + dx;
      3: a = b + ix;
      4: a = b + ix * (64'd1 << sc) + dx;
      5: a = p + dx;
      6: begin a = b; end
      default: a = b + dx;
    endcase
    a = a & MASK;
    w = (md == 6) ? ((b + 1) & MASK) : a;
    @(negedge clk);
    e_vld = v;
    e_wen = v && (md == 6 || md == 7);
    if (v) begin e_addr = a; e_wb = w; end
    check(tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset");
    rst = 1'b0;
    @(negedge clk);
    check("R1 after reset");

    issue(1, 0, 0, 0, 32'h1234, 0, 32'h80, 0, "R4 abs R3 byte negative");
    issue(1, 0, 0, 0, 32'h1234, 0, 32'h7F, 0, "R4 abs R3 byte positive");
    issue(1, 0, 1, 0, 0, 0, 32'hABCD_8000, 0, "R3 half negative");
    issue(1, 0, 1, 0, 0, 0, 32'hABCD_7FFF, 0, "R3 half positive");
    issue(1, 0, 3, 0, 0, 0, 32'h8000_0001, 0, "R3 code3 full width");
    issue(1, 1, 0, 0, 32'hCAFE_0000, 5, 32'hFF, 0, "R5 indirect");
    issue(1, 2, 0, 0, 32'h1000, 0, 32'hFC, 0, "R6 disp negative");
    issue(1, 2, 2, 0, 32'h1000, 0, 32'h0001_0000, 0, "R6 disp 32");
    issue(1, 3, 2, 0, 32'h100, 32'h23, 32'h5555, 0, "R7 bidx ignores disp");
    for (int s = 0; s < 4; s++)
      issue(1, 4, 0, s, 32'h4000, 32'h11, 32'hF0, 0, "R8 scaled");
    issue(1, 5, 1, 0, 32'h9999, 0, 32'hFFF0, 32'h2000, "R9 pcrel");
    issue(1, 6, 0, 0, 32'h500, 0, 32'h10, 0, "R10 autoinc");
    issue(1, 6, 0, 0, 32'hFFFF_FFFF, 0, 0, 0, "R10 R13 autoinc wrap");
    issue(1, 7, 0, 0, 32'h500, 0, 32'h08, 0, "R11 autoindex");
    issue(1, 2, 0, 0, 32'hFFFF_FFFF, 0, 32'h02, 0, "R13 wrap");
    issue(0, 7, 0, 0, 32'h7777, 0, 32'h01, 0, "R14 R12 idle hold");
    issue(0, 1, 0, 0, 32'h1, 0, 0, 0, "R2 idle");
    issue(1, 3, 0, 0, 32'h10, 32'h20, 0, 0, "R12 no wb mode3");

    for (int i = 0; i < 400; i++)
      issue(($urandom % 4) != 0, $urandom % 8, $urandom % 4, $urandom % 4,
            longint'($urandom), longint'($urandom), longint'($urandom),
            longint'($urandom), "R2 R8 R13 random");

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule